// File: doc/BRIEF.md
# Nonvolatile Wiper Preset Sequencer

This block moves a wiper setting between a volatile working register and a nonvolatile shadow store. A serial command decoder sends it single-cycle strobes: save, restore, readback, and a direct write of the working register. Two board pins also feed it. One is an active-low preset pin; its rising edge forces a reload from the store. The other is an active-low write-protect pin. Save, restore and readback each take a long time. While one of them runs, the ready output is held low. The three durations are parameters counted in clock cycles, so they can be scaled to the real store timing.

The store keeps its contents across the block reset and comes up holding midscale. Every reset ends with an automatic reload of the working register from the store. Both pins are synchronised inside the block before they are used, so a short asynchronous low pulse on the preset pin is caught.

Top module: `wiper_preset_seq`

## Requirements
- R1: While rst_ni is low, wiper_o is 0 and ready_o is low. After rst_ni rises, ready_o stays low for LOAD_CYC cycles. It then rises with wiper_o equal to the store contents.
- R2: Before any save, the store holds midscale, 2^(W-1), which is 0x200 for W=10. The store contents are kept across rst_ni.
- R3: When the block is idle, a save strobe with write-protect released holds ready_o low for exactly SAVE_CYC cycles. When it ends, the store holds the working value.
- R4: When the block is idle, a restore strobe holds ready_o low for exactly LOAD_CYC cycles. When it ends, wiper_o equals the store contents.
- R5: A low-to-high transition of preset_ni starts the same reload as R4, after a two-stage synchroniser. The falling edge alone starts nothing.
- R6: When the block is idle, a readback strobe holds ready_o low for exactly RB_CYC cycles. When it ends, rb_data_o equals the store contents.
- R7: When the block is idle and write-protect is released, wr_en_i loads wr_data_i into wiper_o on the next clock edge.
- R8: While the synchronised wp_ni is low, direct writes are dropped and save strobes are dropped with no busy time. Restore and preset still reload wiper_o.
- R9: Strobes and direct writes that arrive while ready_o is low are ignored. The running operation keeps its length and its result.
- R10: If strobes arrive together in an idle cycle, the order of priority is restore/preset first, then save, then readback, then direct write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| save_i | input | 1 | Save strobe (working register to store) |
| restore_i | input | 1 | Restore strobe (store to working register) |
| readback_i | input | 1 | Readback strobe (store to rb_data_o) |
| wr_en_i | input | 1 | Direct write enable |
| wr_data_i | input | W | Direct write value |
| preset_ni | input | 1 | Asynchronous preset pin; acts on its rising edge |
| wp_ni | input | 1 | Asynchronous write-protect pin, active low |
| wiper_o | output | W | Working wiper register |
| rb_data_o | output | W | Last value read back from the store |
| ready_o | output | 1 | High when idle, low while an operation runs |

## Verification
The in-RTL assertions check four things on every cycle:
- the working register is frozen under write-protect unless a reload completes;
- a save can only start with write-protect released;
- the store changes only on a save commit;
- a running operation never switches kind, and the preset edge pulse lasts one cycle.

Some behaviours can only be shown by the bench scenarios:
- the exact busy lengths and the midscale default;
- the store surviving a reset;
- strobes dropped during a busy window;
- same-cycle priority;
- that a falling preset edge does nothing.

// File: rtl/wps_pkg.sv
package wps_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SAVE = 2'd1,
    ST_LOAD = 2'd2,
    ST_READ = 2'd3
  } wps_state_e;
endpackage

// File: rtl/wps_sync.sv
module wps_sync #(
  parameter int unsigned N = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/wps_nvstore.sv
module wps_nvstore #(
  parameter int unsigned W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         commit_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] data_o
);
  localparam logic [W-1:0] MID = W'(1) << (W - 1);

  // No reset: contents persist across rst_ni, power-up value is midscale.
  logic [W-1:0] mem_q = MID;

  always_ff @(posedge clk_i) begin
    if (commit_i) mem_q <= data_i;
  end

  assign data_o = mem_q;

  p_store_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(data_o));
endmodule

// File: rtl/wps_ctrl.sv
module wps_ctrl
  import wps_pkg::*;
#(
  parameter int unsigned SAVE_CYC = 2_000_000,
  parameter int unsigned LOAD_CYC = 100_000,
  parameter int unsigned RB_CYC   = 12_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic save_req_i,
  input  logic load_req_i,
  input  logic rb_req_i,
  input  logic wr_req_i,
  input  logic wp_ok_i,
  output logic ready_o,
  output logic save_done_o,
  output logic load_done_o,
  output logic rb_done_o,
  output logic wr_ok_o
);
  localparam int unsigned MAX_AB = (SAVE_CYC > LOAD_CYC) ? SAVE_CYC : LOAD_CYC;
  localparam int unsigned MAXC   = (MAX_AB > RB_CYC) ? MAX_AB : RB_CYC;
  localparam int unsigned CW     = $clog2(MAXC + 1);

  wps_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic idle, fin;

  assign idle = (state_q == ST_IDLE);
  assign fin  = !idle && (cnt_q == '0);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    wr_ok_o = 1'b0;
    if (idle) begin
      if (load_req_i) begin
        state_d = ST_LOAD;
        cnt_d   = CW'(LOAD_CYC - 1);
      end else if (save_req_i && wp_ok_i) begin
        state_d = ST_SAVE;
        cnt_d   = CW'(SAVE_CYC - 1);
      end else if (rb_req_i) begin
        state_d = ST_READ;
        cnt_d   = CW'(RB_CYC - 1);
      end else begin
        wr_ok_o = wr_req_i && wp_ok_i;
      end
    end else if (fin) begin
      state_d = ST_IDLE;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  // Reset lands in a reload: power-on auto restore.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_LOAD;
      cnt_q   <= CW'(LOAD_CYC - 1);
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign ready_o     = idle;
  assign save_done_o = fin && (state_q == ST_SAVE);
  assign load_done_o = fin && (state_q == ST_LOAD);
  assign rb_done_o   = fin && (state_q == ST_READ);

  p_op_locked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idle && cnt_q != '0) |=> (state_q == $past(state_q)));
  p_save_needs_wp_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SAVE && $past(state_q) == ST_IDLE) |-> $past(wp_ok_i));
endmodule

// File: rtl/wiper_preset_seq.sv
module wiper_preset_seq #(
  parameter int unsigned W        = 10,
  parameter int unsigned SAVE_CYC = 2_000_000,
  parameter int unsigned LOAD_CYC = 100_000,
  parameter int unsigned RB_CYC   = 12_000
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         save_i,
  input  logic         restore_i,
  input  logic         readback_i,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         preset_ni,
  input  logic         wp_ni,
  output logic [W-1:0] wiper_o,
  output logic [W-1:0] rb_data_o,
  output logic         ready_o
);
  logic [1:0] pins_s;
  logic preset_prev_q, preset_rise;
  logic save_done, load_done, rb_done, wr_ok;
  logic [W-1:0] nv_q, wiper_q, rb_q;

  // bit0 preset (idle high), bit1 write-protect (reset as protected)
  wps_sync #(.N(2), .RST_VAL(2'b01)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({wp_ni, preset_ni}),
    .q_o   (pins_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) preset_prev_q <= 1'b1;
    else         preset_prev_q <= pins_s[0];
  end

  assign preset_rise = pins_s[0] && !preset_prev_q;

  wps_ctrl #(.SAVE_CYC(SAVE_CYC), .LOAD_CYC(LOAD_CYC), .RB_CYC(RB_CYC)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .save_req_i (save_i),
    .load_req_i (restore_i || preset_rise),
    .rb_req_i   (readback_i),
    .wr_req_i   (wr_en_i),
    .wp_ok_i    (pins_s[1]),
    .ready_o    (ready_o),
    .save_done_o(save_done),
    .load_done_o(load_done),
    .rb_done_o  (rb_done),
    .wr_ok_o    (wr_ok)
  );

  wps_nvstore #(.W(W)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .commit_i(save_done),
    .data_i  (wiper_q),
    .data_o  (nv_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wiper_q <= '0;
      rb_q    <= '0;
    end else begin
      if (load_done)  wiper_q <= nv_q;
      else if (wr_ok) wiper_q <= wr_data_i;
      if (rb_done)    rb_q    <= nv_q;
    end
  end

  assign wiper_o   = wiper_q;
  assign rb_data_o = rb_q;

  p_wiper_frozen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pins_s[1] && !load_done) |=> $stable(wiper_q));
  p_rise_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    preset_rise |=> !preset_rise);
endmodule

// File: tb/wiper_preset_seq_test.sv
`timescale 1ns/1ps
module wiper_preset_seq_test;
  localparam int W = 10;
  localparam int SAVE_CYC = 40;
  localparam int LOAD_CYC = 12;
  localparam int RB_CYC = 6;
  localparam logic [W-1:0] MID = 10'h200;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic save_i = 0, restore_i = 0, readback_i = 0, wr_en_i = 0;
  logic [W-1:0] wr_data_i = '0;
  logic preset_ni = 1'b1, wp_ni = 1'b1;
  logic [W-1:0] wiper_o, rb_data_o;
  logic ready_o;

  int vectors = 0, errors = 0;
  logic [W-1:0] exp_w, exp_nv;
  bit wp_hi = 1'b1;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wiper_preset_seq #(.W(W), .SAVE_CYC(SAVE_CYC), .LOAD_CYC(LOAD_CYC), .RB_CYC(RB_CYC)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .save_i(save_i), .restore_i(restore_i),
    .readback_i(readback_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .preset_ni(preset_ni), .wp_ni(wp_ni), .wiper_o(wiper_o),
    .rb_data_o(rb_data_o), .ready_o(ready_o)
  );

  // 0 save, 1 restore, 2 readback
  function automatic int busy_len(int op, bit wp);
    case (op)
      0: return wp ? SAVE_CYC : 0;
      1: return LOAD_CYC;
      default: return RB_CYC;
    endcase
  endfunction

  function automatic logic [W-1:0] exp_wr(logic [W-1:0] cur, logic [W-1:0] d, bit wp);
    return wp ? d : cur;
  endfunction

  task automatic check(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic count_low(output int n);
    n = 0;
    while (!ready_o && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 wiper in reset", wiper_o, 0);
    check("R1 ready in reset", ready_o, 0);
    rst_ni = 1'b1;
    begin
      int n;
      count_low(n);
      check("R1 reload length", n, LOAD_CYC);
    end
    exp_w = exp_nv;
    check("R1 reloaded wiper", wiper_o, exp_w);
    wp_hi = 1'b1;
    wp_ni = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic set_wp(bit v);
    wp_ni = v;
    wp_hi = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_write(logic [W-1:0] d);
    wr_en_i = 1'b1;
    wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
    exp_w = exp_wr(exp_w, d, wp_hi);
    check(wp_hi ? "R7 direct write" : "R8 write blocked", wiper_o, exp_w);
  endtask

  task automatic do_cmd(int op);
    int n;
    case (op)
      0: save_i = 1'b1;
      1: restore_i = 1'b1;
      default: readback_i = 1'b1;
    endcase
    @(negedge clk);
    save_i = 1'b0; restore_i = 1'b0; readback_i = 1'b0;
    count_low(n);
    case (op)
      0: begin
        check(wp_hi ? "R3 save busy" : "R8 save blocked busy", n, busy_len(0, wp_hi));
        if (wp_hi) exp_nv = exp_w;
      end
      1: begin
        check("R4 restore busy", n, busy_len(1, wp_hi));
        exp_w = exp_nv;
        check(wp_hi ? "R4 restore wiper" : "R8 restore under wp", wiper_o, exp_w);
      end
      default: begin
        check("R6 readback busy", n, busy_len(2, wp_hi));
        check("R6 readback value", rb_data_o, exp_nv);
      end
    endcase
  endtask

  task automatic do_preset();
    int n, wait_n;
    preset_ni = 1'b0;
    repeat (4) @(negedge clk);
    check("R5 falling edge inert", ready_o, 1);
    preset_ni = 1'b1;
    wait_n = 0;
    while (ready_o && wait_n < 10) begin
      wait_n++;
      @(negedge clk);
    end
    count_low(n);
    check("R5 preset busy", n, LOAD_CYC);
    exp_w = exp_nv;
    check("R5 preset wiper", wiper_o, exp_w);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    if (!done) $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    exp_nv = MID;
    exp_w = '0;
    @(negedge clk);
    do_reset();
    check("R2 midscale default", wiper_o, MID);
    do_cmd(2);
    check("R2 store midscale", rb_data_o, MID);

    // R7 then R3 save, readback
    do_write(10'h155);
    do_cmd(0);
    do_cmd(2);
    do_write(10'h0AA);

    // R2 store survives reset, R1 reloads it
    do_reset();
    check("R2 store kept across reset", wiper_o, 10'h155);

    // R8 protection
    set_wp(1'b0);
    do_write(10'h3FF);
    do_cmd(0);
    do_cmd(2);
    do_write(10'h011);
    do_cmd(1);
    do_preset();
    set_wp(1'b1);

    // R9 strobes during busy are ignored
    do_write(10'h2C3);
    save_i = 1'b1;
    @(negedge clk);
    save_i = 1'b0;
    repeat (5) @(negedge clk);
    wr_en_i = 1'b1; wr_data_i = 10'h001; restore_i = 1'b1; readback_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0; restore_i = 1'b0; readback_i = 1'b0;
    begin
      int n;
      count_low(n);
      check("R9 busy length kept", n + 6, SAVE_CYC);
    end
    exp_nv = 10'h2C3;
    check("R9 write ignored", wiper_o, 10'h2C3);
    do_cmd(2);

    // R10 restore beats save in same cycle
    do_write(10'h07E);
    save_i = 1'b1; restore_i = 1'b1; readback_i = 1'b1; wr_en_i = 1'b1; wr_data_i = 10'h100;
    @(negedge clk);
    save_i = 1'b0; restore_i = 1'b0; readback_i = 1'b0; wr_en_i = 1'b0;
    begin
      int n;
      count_low(n);
      check("R10 restore wins length", n, LOAD_CYC);
    end
    exp_w = exp_nv;
    check("R10 restore wins value", wiper_o, exp_w);
    // R10 save beats readback
    do_write(10'h0F0);
    save_i = 1'b1; readback_i = 1'b1;
    @(negedge clk);
    save_i = 1'b0; readback_i = 1'b0;
    begin
      int n;
      count_low(n);
      check("R10 save wins length", n, SAVE_CYC);
    end
    exp_nv = 10'h0F0;
    do_cmd(2);

    // random mix
    for (int i = 0; i < 60; i++) begin
      int r = $urandom % 7;
      case (r)
        0, 1: do_write(W'($urandom));
        2: do_cmd(0);
        3: do_cmd(1);
        4: do_cmd(2);
        5: do_preset();
        default: set_wp(($urandom % 3) != 0);
      endcase
    end
    set_wp(1'b1);
    do_cmd(2);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule